// File: doc/BRIEF.md
# Debug Session Status Tracker

This block keeps the status of one on-chip debug session. Software starts or stops a session through a single arm bit on a small register write port. Once a session is running, external match logic moves a 3-bit sequencer state forward. A separate strobe marks each trace line stored, and an internal event can end the session at any time. The block reports a read-only status byte, the live sequencer state and a trace-line readout.

The block handles the two ways a session can stop in different ways. If software clears the arm bit, the last sequencer state stays visible. If an internal event ends the session, the state returns to zero. A trace-buffer-full flag records that a whole buffer of lines has been stored since the last arming. This flag survives the system reset and is cleared only by power-on reset or by re-arming. The comparators, the trace memory and the bus decode sit outside the block.

Top module: `dbg_session_status`

## Requirements
- R1: While and after power-on reset (rst_ni low, asynchronous), armed_o is 0, state_o is 3'b000, status_o is 8'h00 and line_cnt_o is 8'h00.
- R2: A write with wr_en_i=1, wr_sel_i=0 (control register) and wr_arm_i=1 arms the session on that edge. From the next cycle armed_o=1, state_o=3'b001, the line count is 0 and the full flag is 0. This also applies when the session is already armed.
- R3: While armed, with no control write and no session-end event, a cycle with nxt_req_i=1 loads nxt_state_i into state_o for the following cycle.
- R4: A control write with wr_arm_i=0 disarms the session, and state_o keeps the value it had before the write.
- R5: While armed, with no control write, sess_end_i=1 disarms the session and forces state_o to 3'b000. It takes priority over a next-state request in the same cycle.
- R6: While disarmed, nxt_req_i and line_stb_i change neither state_o nor the line count.
- R7: While armed, with no control write, each cycle with line_stb_i=1 adds one to the line index, modulo LINES (64 by default). A strobe in a session-end cycle still counts.
- R8: The full flag is set by the LINES-th counted strobe since the last arming. It then stays set until an arming write or power-on reset.
- R9: With sys_rst_ni low at a clock edge, the session is disarmed, state_o becomes 0 and the line index becomes 0. The full flag keeps its value. This reset wins over any write or event in that cycle.
- R10: status_o carries the full flag at bit 7 and state_o at bits 2:0, and bits 6:3 read 0. A write with wr_sel_i=1 (status register) changes nothing.
- R11: line_cnt_o carries the full flag at bit 7 and the line index in its low log2(LINES) bits, and all other bits read 0.
- R12: A control write takes priority over sess_end_i, nxt_req_i and line_stb_i in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_ni | input | 1 | System reset, active low, synchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 control, 1 status (ignored) |
| wr_arm_i | input | 1 | Arm bit value written to control |
| nxt_req_i | input | 1 | Next-state request from match logic |
| nxt_state_i | input | 3 | Requested next sequencer state |
| line_stb_i | input | 1 | One trace line stored |
| sess_end_i | input | 1 | Internal session-end event |
| armed_o | output | 1 | Session armed |
| state_o | output | 3 | Live sequencer state |
| status_o | output | 8 | Status byte: full flag and state |
| line_cnt_o | output | 8 | Line readout: full flag and line index |

## Verification
The assertions check on every cycle the register layout of both readouts, and that the full flag never drops except on arming. They also check the single-cycle effect of each event: the arming values, disarm with the state held, session end to state zero, the next-state load, counter advance and the system reset keeping the flag. Some behaviour needs longer scenarios, so only the bench's sequences can show it. These are the full flag rising on exactly the sixty-fourth strobe after arming, the index wrapping at that point, power-on reset clearing a flag that the system reset left alone, and the priority ordering in long random traffic.

// File: rtl/dbg_stat_pkg.sv
package dbg_stat_pkg;
  localparam int unsigned ST_W = 3;
  typedef logic [ST_W-1:0] seq_st_t;
  localparam seq_st_t ST_IDLE  = seq_st_t'(0);
  localparam seq_st_t ST_FIRST = seq_st_t'(1);

  // qualified, mutually ordered session events
  typedef struct packed {
    logic sys_clr;
    logic arm_set;
    logic arm_clr;
    logic sess_end;
    logic adv;
    logic stb;
  } sess_evt_t;
endpackage

// File: rtl/dbg_evt_decode.sv
module dbg_evt_decode
  import dbg_stat_pkg::*;
(
  input  logic      sys_rst_ni,
  input  logic      wr_en_i,
  input  logic      wr_sel_i,
  input  logic      wr_arm_i,
  input  logic      nxt_req_i,
  input  logic      line_stb_i,
  input  logic      sess_end_i,
  input  logic      armed_i,
  output sess_evt_t evt_o
);
  logic wr_ctl;
  logic live;

  // status-register writes (wr_sel_i=1) decode to nothing
  assign wr_ctl = wr_en_i & ~wr_sel_i;
  assign live   = sys_rst_ni & ~wr_ctl & armed_i;

  always_comb begin
    evt_o          = '0;
    evt_o.sys_clr  = ~sys_rst_ni;
    evt_o.arm_set  = sys_rst_ni & wr_ctl & wr_arm_i;
    evt_o.arm_clr  = sys_rst_ni & wr_ctl & ~wr_arm_i;
    evt_o.sess_end = live & sess_end_i;
    evt_o.adv      = live & ~sess_end_i & nxt_req_i;
    evt_o.stb      = live & line_stb_i;
  end
endmodule

// File: rtl/dbg_seq_track.sv
module dbg_seq_track
  import dbg_stat_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  sess_evt_t evt_i,
  input  seq_st_t   nxt_state_i,
  output logic      armed_o,
  output seq_st_t   state_o
);
  logic    armed_q;
  seq_st_t state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      state_q <= ST_IDLE;
    end else if (evt_i.sys_clr) begin
      armed_q <= 1'b0;
      state_q <= ST_IDLE;
    end else if (evt_i.arm_set) begin
      armed_q <= 1'b1;
      state_q <= ST_FIRST;
    end else if (evt_i.arm_clr) begin
      armed_q <= 1'b0;             // state held for inspection
    end else if (evt_i.sess_end) begin
      armed_q <= 1'b0;
      state_q <= ST_IDLE;
    end else if (evt_i.adv) begin
      state_q <= nxt_state_i;
    end
  end

  assign armed_o = armed_q;
  assign state_o = state_q;
endmodule

// File: rtl/dbg_line_track.sv
module dbg_line_track
  import dbg_stat_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  sess_evt_t        evt_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o
);
  localparam logic [CNT_W-1:0] LAST = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else if (evt_i.sys_clr) begin
      cnt_q  <= '0;                // full flag survives system reset
    end else if (evt_i.arm_set) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else if (evt_i.stb) begin
      cnt_q  <= cnt_q + 1'b1;
      if (cnt_q == LAST) full_q <= 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign full_o = full_q;
endmodule

// File: rtl/dbg_rd_mux.sv
module dbg_rd_mux
  import dbg_stat_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic             full_i,
  input  seq_st_t          state_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [7:0]       status_o,
  output logic [7:0]       line_o
);
  localparam int unsigned ST_PAD = 7 - ST_W;

  assign status_o = {full_i, {ST_PAD{1'b0}}, state_i};

  generate
    if (CNT_W < 7) begin : g_pad
      assign line_o = {full_i, {(7 - CNT_W){1'b0}}, cnt_i};
    end else begin : g_nopad
      assign line_o = {full_i, cnt_i};
    end
  endgenerate
endmodule

// File: rtl/dbg_session_status.sv
module dbg_session_status
  import dbg_stat_pkg::*;
#(
  parameter int unsigned LINES = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sys_rst_ni,
  input  logic       wr_en_i,
  input  logic       wr_sel_i,
  input  logic       wr_arm_i,
  input  logic       nxt_req_i,
  input  logic [2:0] nxt_state_i,
  input  logic       line_stb_i,
  input  logic       sess_end_i,
  output logic       armed_o,
  output logic [2:0] state_o,
  output logic [7:0] status_o,
  output logic [7:0] line_cnt_o
);
  localparam int unsigned CNT_W = $clog2(LINES);

  sess_evt_t        evt;
  logic             armed;
  seq_st_t          state;
  logic [CNT_W-1:0] cnt;
  logic             full;

  dbg_evt_decode u_dec (
    .sys_rst_ni (sys_rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_i),
    .wr_arm_i   (wr_arm_i),
    .nxt_req_i  (nxt_req_i),
    .line_stb_i (line_stb_i),
    .sess_end_i (sess_end_i),
    .armed_i    (armed),
    .evt_o      (evt)
  );

  dbg_seq_track u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       (evt),
    .nxt_state_i (nxt_state_i),
    .armed_o     (armed),
    .state_o     (state)
  );

  dbg_line_track #(.CNT_W(CNT_W)) u_line (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt),
    .cnt_o  (cnt),
    .full_o (full)
  );

  dbg_rd_mux #(.CNT_W(CNT_W)) u_rd (
    .full_i   (full),
    .state_i  (state),
    .cnt_i    (cnt),
    .status_o (status_o),
    .line_o   (line_cnt_o)
  );

  assign armed_o = armed;
  assign state_o = state;
endmodule

// File: rtl/dbg_session_status_chk.sv
module dbg_session_status_chk #(
  parameter int unsigned LINES = 64
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sys_rst_ni,
  input logic       wr_en_i,
  input logic       wr_sel_i,
  input logic       wr_arm_i,
  input logic       nxt_req_i,
  input logic [2:0] nxt_state_i,
  input logic       line_stb_i,
  input logic       sess_end_i,
  input logic       armed_o,
  input logic [2:0] state_o,
  input logic [7:0] status_o,
  input logic [7:0] line_cnt_o
);
  localparam int unsigned CNT_W = $clog2(LINES);

  logic wr_ctl;
  assign wr_ctl = wr_en_i & ~wr_sel_i;

  p_arm_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_ni && wr_ctl && wr_arm_i |=>
      armed_o && state_o == 3'b001 && line_cnt_o == 8'h00);

  p_adv_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_ni && !wr_ctl && armed_o && !sess_end_i && nxt_req_i |=>
      state_o == $past(nxt_state_i));

  p_sw_disarm_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_ni && wr_ctl && !wr_arm_i |=> !armed_o && $stable(state_o));

  p_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_ni && !wr_ctl && armed_o && sess_end_i |=>
      !armed_o && state_o == 3'b000);

  p_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_ni && !wr_ctl && !armed_o |=>
      !armed_o && $stable(state_o) && $stable(line_cnt_o[CNT_W-1:0]));

  p_cnt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_ni && !wr_ctl && armed_o && line_stb_i |=>
      line_cnt_o[CNT_W-1:0] == CNT_W'($past(line_cnt_o[CNT_W-1:0]) + 1'b1));

  p_full_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[7] && !(sys_rst_ni && wr_ctl && wr_arm_i) |=> status_o[7]);

  p_sysrst_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sys_rst_ni |=> !armed_o && state_o == 3'b000 &&
      line_cnt_o[CNT_W-1:0] == '0 && status_o[7] == $past(status_o[7]));

  p_fmt_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[6:3] == 4'h0 && status_o[2:0] == state_o);

  p_rd_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_cnt_o[7] == status_o[7] && line_cnt_o[6] == 1'b0);

  p_prio_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_ni && wr_ctl && armed_o && sess_end_i && wr_arm_i |=>
      armed_o && state_o == 3'b001);
endmodule

bind dbg_session_status dbg_session_status_chk #(.LINES(LINES)) u_chk (.*);

// File: tb/sim_dbg_session_status.sv
module sim_dbg_session_status;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sys_rst_ni = 1'b1;
  logic       wr_en_i = 1'b0, wr_sel_i = 1'b0, wr_arm_i = 1'b0;
  logic       nxt_req_i = 1'b0;
  logic [2:0] nxt_state_i = 3'b000;
  logic       line_stb_i = 1'b0, sess_end_i = 1'b0;
  logic       armed_o;
  logic [2:0] state_o;
  logic [7:0] status_o, line_cnt_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // reference model
  bit       m_armed;
  bit [2:0] m_state;
  bit [5:0] m_cnt;
  bit       m_full;

  dbg_session_status u0 (.*);

  always #4 clk_i = ~clk_i;

  function automatic bit [7:0] exp_status();
    return {m_full, 4'h0, m_state};
  endfunction

  function automatic bit [7:0] exp_line();
    return {m_full, 1'b0, m_cnt};
  endfunction

  task automatic model_edge();
    bit wc;
    wc = wr_en_i && !wr_sel_i;
    if (!sys_rst_ni) begin
      m_armed = 0; m_state = 0; m_cnt = 0;
    end else if (wc) begin
      if (wr_arm_i) begin m_armed = 1; m_state = 3'b001; m_cnt = 0; m_full = 0; end
      else m_armed = 0;
    end else if (m_armed) begin
      if (line_stb_i) begin
        if (m_cnt == 6'd63) m_full = 1;
        m_cnt = m_cnt + 6'd1;
      end
      if (sess_end_i) begin m_armed = 0; m_state = 0; end
      else if (nxt_req_i) m_state = nxt_state_i;
    end
  endtask

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk(req, "armed", {7'd0, armed_o}, {7'd0, m_armed});
    chk(req, "state", {5'd0, state_o}, {5'd0, m_state});
    chk(req, "status", status_o, exp_status());
    chk(req, "line", line_cnt_o, exp_line());
  endtask

  task automatic idle_in();
    wr_en_i = 0; wr_sel_i = 0; wr_arm_i = 0; nxt_req_i = 0;
    nxt_state_i = 0; line_stb_i = 0; sess_end_i = 0; sys_rst_ni = 1;
  endtask

  // inputs are held from negedge; model follows posedge; check at next negedge
  task automatic step(string req);
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
    chk_all(req);
    idle_in();
  endtask

  task automatic por();
    rst_ni = 0;
    m_armed = 0; m_state = 0; m_cnt = 0; m_full = 0;
    @(negedge clk_i);
    chk_all("R1");
    rst_ni = 1;
    @(negedge clk_i);
  endtask

  task automatic arm(string req);
    wr_en_i = 1; wr_sel_i = 0; wr_arm_i = 1; step(req);
  endtask

  initial begin
    void'($urandom(32'd2024));
    idle_in();
    @(negedge clk_i);
    por();                                           // R1
    chk_all("R1");

    arm("R2");                                       // R2
    nxt_req_i = 1; nxt_state_i = 3'd5; step("R3");  // R3
    nxt_req_i = 1; nxt_state_i = 3'd6; sess_end_i = 1; step("R5");  // R5 priority
    nxt_req_i = 1; nxt_state_i = 3'd4; line_stb_i = 1; step("R6");  // R6 ignored
    line_stb_i = 1; step("R6");

    arm("R2");
    nxt_req_i = 1; nxt_state_i = 3'd6; step("R3");
    wr_en_i = 1; wr_arm_i = 0; line_stb_i = 1; step("R4");  // R4 state kept
    chk("R4", "held", {5'd0, state_o}, 8'h06);

    arm("R2");
    for (int i = 0; i < 64; i++) begin
      line_stb_i = 1; step(i == 63 ? "R8" : "R7");           // R7, R8
    end
    chk("R8", "full", {7'd0, status_o[7]}, 8'h01);
    chk("R11", "line", line_cnt_o, 8'h80);                 // R11
    line_stb_i = 1; step("R7");

    wr_en_i = 1; wr_sel_i = 1; wr_arm_i = 0; step("R10");  // R10 ignored
    wr_en_i = 1; wr_sel_i = 1; wr_arm_i = 1; step("R10");

    sys_rst_ni = 0; wr_en_i = 1; wr_arm_i = 1; step("R9");  // R9
    chk("R9", "full kept", {7'd0, status_o[7]}, 8'h01);

    arm("R8");
    chk("R8", "cleared", {7'd0, status_o[7]}, 8'h00);

    sess_end_i = 1; wr_en_i = 1; wr_arm_i = 1; step("R12"); // R12
    sess_end_i = 1; wr_en_i = 1; wr_arm_i = 0; step("R12");
    chk("R12", "state", {5'd0, state_o}, 8'h01);

    arm("R2");
    for (int i = 0; i < 64; i++) begin line_stb_i = 1; step("R7"); end
    por();
    chk("R1", "full cleared", status_o, 8'h00);

    for (int i = 0; i < 5000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      wr_en_i     = (r < 8);
      wr_sel_i    = (r < 2);
      wr_arm_i    = (r < 6);
      nxt_req_i   = ($urandom_range(0, 3) == 0);
      nxt_state_i = 3'($urandom_range(0, 7));
      line_stb_i  = ($urandom_range(0, 1) == 0);
      sess_end_i  = ($urandom_range(0, 99) < 2);
      sys_rst_ni  = ($urandom_range(0, 299) != 0);
      step("R3 R7 R12");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule